// File: doc/BRIEF.md
# Line Interface Activity-Timeout Power Controller

This block decides whether a serial line interface is powered, waking or shut down. It samples the logic-level transmit data inputs and the sliced receive inputs. It treats any change on any of them as line activity. After a programmable number of clock ticks with no activity, it turns off the transmitters, the charge pump and the ready flag. The receivers stay on in that case. The shutdown is sticky. The block comes back only on new line activity or on the force-on control. Once a wake starts, the pump comes on at once and the transmitters follow after a fixed wake delay.

Two control inputs override the automatic behaviour. An active-low force-off input shuts everything down at once, including the standard receivers, and it beats every other input. An active-high force-on input, while force-off is high, keeps the interface up and holds the inactivity timer in reset, so its falling edge starts a full new window. One receiver lane feeds a monitor output that works in every mode. All asynchronous inputs pass through two-flop synchronizers first, so an input change reaches the state three clocks later.

Top module: `line_power_ctrl`

## Requirements
- R1: During and right after reset, tx_en, pump_en and rx_en are 1 and the idle timer starts fresh. ready is 0 until supply_good has passed its synchronizer.
- R2: With force_off_n=1 and force_on=0, once IDLE_TICKS clocks pass with no change on tx_in or rx_in, tx_en, pump_en and ready go to 0 while rx_en stays 1.
- R3: Any change on any tx_in or rx_in bit restarts the idle window. This holds even when the change lands on the clock where the window would expire.
- R4: While force_on=1 and force_off_n=1, a powered interface never shuts down, however long the lines stay quiet.
- R5: Once shut down, the block stays down with no line change and force_on=0. A release of force_off_n alone does not wake it.
- R6: A line change, or force_on=1 with force_off_n=1, wakes a shut-down block. pump_en and ready (with supply good) rise at once, and tx_en rises WAKE_TICKS clocks later.
- R7: force_off_n=0 drives tx_en, pump_en, ready and rx_en to 0 within three clocks. It overrides force_on and line changes.
- R8: When force_on falls, the block stays up for a full IDLE_TICKS window counted from the synchronized fall.
- R9: ready is 1 only while the pump is enabled and the synchronized supply_good is 1. It drops on every shutdown.
- R10: mon_out equals rx_in[MON_IDX] delayed by two clocks, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | NTX | Logic-level transmit data inputs |
| rx_in | input | NRX | Sliced receive inputs |
| force_off_n | input | 1 | Active-low forced shutdown |
| force_on | input | 1 | Active-high keep-alive, disables auto shutdown |
| supply_good | input | 1 | Negative rail has reached its threshold |
| tx_en | output | 1 | Transmitter drive enable (0 = high impedance) |
| rx_en | output | 1 | Standard receiver output enable |
| pump_en | output | 1 | Charge pump enable |
| ready | output | 1 | Ready to transmit |
| mon_out | output | 1 | Monitor receiver output |

## Verification
Line activity and idle expiry can fall in the same clock. The bench provokes this by toggling a receive input so that its synchronized edge arrives exactly on the expiry tick. It then checks that the interface stays up and that a full new window follows. Force-off and force-on can also be active together. The bench holds both asserted and keeps the transmit lines toggling, and it judges the result on tx_en, pump_en and rx_en all staying low.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_WAKE = 2'd1,
    PWR_OFF  = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/lpc_reset_sync.sv
module lpc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] q_d;

  always_comb begin
    meta_d = d;
    q_d    = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      q      <= q_d;
    end
  end
endmodule

// File: rtl/lpc_activity.sv
module lpc_activity #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic         act
);
  logic [W-1:0] prev_q;
  logic [W-1:0] bit_chg;

  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lines[g];
    end
    assign bit_chg[g] = lines[g] ^ prev_q[g];
  end

  assign act = |bit_chg;
endmodule

// File: rtl/lpc_tick_counter.sv
module lpc_tick_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    hit     = !clr && at_last;
    if (clr || at_last) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpc_power_fsm.sv
module lpc_power_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_n,
  input  logic       keep_on,
  input  logic       act,
  input  logic       idle_hit,
  input  logic       wake_hit,
  output pwr_state_t state
);
  pwr_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      PWR_ON: begin
        if (!off_n || idle_hit) state_d = PWR_OFF;
      end
      PWR_WAKE: begin
        if (!off_n)        state_d = PWR_OFF;
        else if (wake_hit) state_d = PWR_ON;
      end
      PWR_OFF: begin
        if (off_n && (act || keep_on)) state_d = PWR_WAKE;
      end
      default: state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_ON;
    else        state <= state_d;
  end
endmodule

// File: rtl/line_power_ctrl.sv
module line_power_ctrl
  import lpc_pkg::*;
#(
  parameter int NTX        = 2,
  parameter int NRX        = 2,
  parameter int MON_IDX    = 0,
  parameter int IDLE_TICKS = 3_000_000,
  parameter int WAKE_TICKS = 10_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NTX-1:0] tx_in,
  input  logic [NRX-1:0] rx_in,
  input  logic           force_off_n,
  input  logic           force_on,
  input  logic           supply_good,
  output logic           tx_en,
  output logic           rx_en,
  output logic           pump_en,
  output logic           ready,
  output logic           mon_out
);
  localparam int NLINE = NTX + NRX;
  localparam int SW    = NLINE + 3;
  localparam logic [SW-1:0] SYNC_RST = SW'(4);

  logic            rst_i_n;
  logic [SW-1:0]   sync_q;
  logic [NLINE-1:0] line_s;
  logic            off_n_s;
  logic            keep_on_s;
  logic            sgood_s;
  logic            act;
  logic            idle_clr;
  logic            idle_hit;
  logic            wake_clr;
  logic            wake_hit;
  pwr_state_t      state;

  lpc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  lpc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({tx_in, rx_in, force_off_n, force_on, supply_good}),
    .q     (sync_q)
  );

  assign line_s    = sync_q[SW-1:3];
  assign off_n_s   = sync_q[2];
  assign keep_on_s = sync_q[1];
  assign sgood_s   = sync_q[0];

  lpc_activity #(.W(NLINE)) u_act (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lines (line_s),
    .act   (act)
  );

  assign idle_clr = act || keep_on_s || !off_n_s || (state != PWR_ON);
  assign wake_clr = (state != PWR_WAKE);

  lpc_tick_counter #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (idle_clr),
    .hit   (idle_hit)
  );

  lpc_tick_counter #(.LIMIT(WAKE_TICKS)) u_wake (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (wake_clr),
    .hit   (wake_hit)
  );

  lpc_power_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .off_n    (off_n_s),
    .keep_on  (keep_on_s),
    .act      (act),
    .idle_hit (idle_hit),
    .wake_hit (wake_hit),
    .state    (state)
  );

  assign tx_en   = (state == PWR_ON);
  assign pump_en = (state != PWR_OFF);
  assign ready   = pump_en && sgood_s;
  assign rx_en   = off_n_s;
  assign mon_out = line_s[MON_IDX];
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int NTX     = 2,
  parameter int NRX     = 2,
  parameter int MON_IDX = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NTX-1:0] tx_in,
  input logic [NRX-1:0] rx_in,
  input logic           force_off_n,
  input logic           force_on,
  input logic           tx_en,
  input logic           rx_en,
  input logic           pump_en,
  input logic           mon_out
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
  end

  // R7: forced shutdown reaches the outputs three clocks after the input
  a_r7_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd7) && !$past(force_off_n, 3) |-> !pump_en && !tx_en);

  // R7: receiver enable follows force-off through the synchronizer
  a_r7_rx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd7) |-> rx_en == $past(force_off_n, 2));

  // R10: monitor lane is live in every mode
  a_r10_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd7) |-> mon_out == $past(rx_in[MON_IDX], 2));

  // R4: force-on with force-off released keeps a running interface running
  a_r4_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd7) && $past(tx_en) && $past(force_on, 3) && $past(force_off_n, 3)
    |-> tx_en);

  // R5: a quiet line without force-on leaves a shut-down block shut down
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd7) && !$past(pump_en) && !$past(force_on, 3)
    && ($past({tx_in, rx_in}, 3) == $past({tx_in, rx_in}, 4))
    |-> !pump_en);

  // R6: transmitters never come up on the same clock as the pump
  a_r6_wake_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> !tx_en);
endmodule

bind line_power_ctrl lpc_checker #(
  .NTX     (NTX),
  .NRX     (NRX),
  .MON_IDX (MON_IDX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_in       (tx_in),
  .rx_in       (rx_in),
  .force_off_n (force_off_n),
  .force_on    (force_on),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .pump_en     (pump_en),
  .mon_out     (mon_out)
);

// File: tb/sim_line_power_ctrl.sv
`timescale 1ns/1ps
module sim_line_power_ctrl;
  localparam int NTX  = 2;
  localparam int NRX  = 2;
  localparam int IDLE = 40;
  localparam int WAKE = 8;
  localparam int NV   = 19;

  // fields: tx[22:21] rx[20:19] off_n[18] on[17] sgood[16] wait[15:8]
  //         expect {tx_en,pump_en,rx_en,ready}[7:4] requirement[3:0]
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 8'd3,            4'b1111, 4'd3}, // R3 line change restarts window
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 8'(IDLE - 2),    4'b1111, 4'd2}, // R2 still inside window
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 8'd2,            4'b0010, 4'd2}, // R2 expired, receivers on
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 8'd20,           4'b0010, 4'd5}, // R5 sticky
    {2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 8'd3,            4'b0000, 4'd7}, // R7 forced, receivers off
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 8'd5,            4'b0010, 4'd5}, // R5 release alone: stays down
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 8'd3,            4'b0111, 4'd6}, // R6 edge wakes pump
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 8'(WAKE - 1),    4'b0111, 4'd6}, // R6 wake delay running
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 8'd1,            4'b1111, 4'd6}, // R6 transmitters up
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 8'd3,            4'b1111, 4'd4}, // R4 force-on
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 8'd60,           4'b1111, 4'd4}, // R4 long quiet
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 8'(IDLE + 1),    4'b1111, 4'd8}, // R8 full window after fall
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 8'd1,            4'b0010, 4'd8}, // R8 expiry
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 8'd3,            4'b0110, 4'd9}, // R9 no supply: not ready
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 8'd3,            4'b0111, 4'd9}, // R9 supply good: ready
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 8'd10,           4'b1111, 4'd9}, // R9 fully up
    {2'b10, 2'b01, 1'b0, 1'b1, 1'b1, 8'd3,            4'b0000, 4'd7}, // R7 beats force-on and edges
    {2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 8'd10,           4'b0000, 4'd7}, // R7 edges ignored while forced
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 8'd3,            4'b0111, 4'd6}  // R6 force-on wakes
  };

  logic           clk;
  logic           rst_n;
  logic [NTX-1:0] tx_in;
  logic [NRX-1:0] rx_in;
  logic           force_off_n;
  logic           force_on;
  logic           supply_good;
  logic           tx_en;
  logic           rx_en;
  logic           pump_en;
  logic           ready;
  logic           mon_out;

  int checks;
  int errors;
  bit done;

  line_power_ctrl #(
    .NTX(NTX), .NRX(NRX), .MON_IDX(0), .IDLE_TICKS(IDLE), .WAKE_TICKS(WAKE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .rx_in(rx_in),
    .force_off_n(force_off_n), .force_on(force_on), .supply_good(supply_good),
    .tx_en(tx_en), .rx_en(rx_en), .pump_en(pump_en), .ready(ready), .mon_out(mon_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk4(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got {tx,pump,rx,rdy}=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {tx_en, pump_en, rx_en, ready};
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tx_in = '0; rx_in = '0;
    force_off_n = 1'b1; force_on = 1'b0; supply_good = 1'b1;
    repeat (3) @(negedge clk);
    chk4("R1 in reset", outs(), 4'b1110);
    rst_n = 1'b1;
    edges(5);
    chk4("R1 after reset", outs(), 4'b1111);

    for (int i = 0; i < NV; i++) begin
      tx_in       = VEC[i][22:21];
      rx_in       = VEC[i][20:19];
      force_off_n = VEC[i][18];
      force_on    = VEC[i][17];
      supply_good = VEC[i][16];
      edges(int'(VEC[i][15:8]));
      chk4($sformatf("R%0d row %0d", VEC[i][3:0], i), outs(), VEC[i][7:4]);
    end

    // R3 corner: activity lands on the expiry tick
    edges(10);
    force_on = 1'b0;
    rx_in = 2'b10;
    edges(3);
    edges(37);
    chk4("R3 before late edge", outs(), 4'b1111);
    rx_in = 2'b11;
    edges(3);
    chk4("R3 edge on expiry tick", outs(), 4'b1111);
    edges(IDLE - 1);
    chk4("R3 new window end-1", outs(), 4'b1111);
    edges(1);
    chk4("R3 new window expired", outs(), 4'b0010);

    // R10: monitor lane under forced shutdown
    force_off_n = 1'b0;
    edges(3);
    rx_in = 2'b10;
    edges(2);
    chk1("R10 monitor low while forced off", mon_out, 1'b0);
    rx_in = 2'b11;
    edges(2);
    chk1("R10 monitor high while forced off", mon_out, 1'b1);
    chk1("R7 still off after line edges", pump_en, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule